// File: doc/BRIEF.md
# Programmable Wide Product-Term Decoder

This block holds a small bank of wide AND decoders that all look at one shared vector of edge inputs. For each decoder, every input bit carries its own two-bit literal selector. The selector either drops the bit from the term, uses it as it is, or uses its inverse. A decoder drives its output high exactly when every literal it keeps is true, so it forms one product term. Any decoder can be cut into two halves at run time. Each half then forms its own narrower product term, which doubles the number of terms the bank offers.

After the product terms comes a small OR plane. Each OR output has an enable mask over all product terms and drives the OR of the terms it enables. Together the two planes give a PAL-style sum-of-products array. The decode path from `edge_in` to `term_o` and `sum_o` is purely combinational. Selectors, split flags and OR masks sit in registers that are loaded through a simple address/data/write-enable port. Input width, decoder count and OR-output count are parameters; the input width defaults to 42.

Configuration map: address `d` (0 ≤ d < N_DEC) loads decoder `d`. In that word, bits `[2i+1:2i]` are the selector of input `i` and bit `2*N_IN` is the split flag. Address `N_DEC + k` loads the enable mask of OR output `k` from bits `[2*N_DEC-1:0]`. Term index `2d` is the lower (or whole) term of decoder `d`, and index `2d+1` is its upper term.

Top module: `wide_pterm_decoder`

## Requirements
- R1: Selector code 01 makes an input a true literal: the term can be high only while that input is 1.
- R2: Selector code 10 makes an input a complemented literal: the term can be high only while that input is 0.
- R3: Selector codes 00 and 11 both remove the input from the term, so the input has no effect on the term output.
- R4: A term, whole or half, in which every input it covers has an ignoring selector (00 or 11) drives a constant 1.
- R5: With its split flag at 0, decoder d drives on term_o[2d] the AND over all N_IN literals, and holds term_o[2d+1] at 0.
- R6: With its split flag at 1, decoder d drives on term_o[2d] the AND of the literals of inputs 0 to N_IN/2-1, and on term_o[2d+1] the AND of the literals of inputs N_IN/2 to N_IN-1. The two halves are independent of each other.
- R7: A configuration write changes the outputs only after the next rising clock edge. A write leaves every other configuration entry unchanged.
- R8: Reset (rst_n low, asynchronous) sets every selector to 00, every split flag to 0 and every OR mask to 0. As a result, the even terms are 1, the odd terms are 0 and all sums are 0.
- R9: sum_o[k] is the OR of the terms whose bits are set in the mask of OR output k (mask bit t enables term t).
- R10: An OR output whose mask is all zero drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Entry select: decoders first, then OR masks |
| cfg_data | input | 85 | Selector map plus split flag, or OR mask in the low bits |
| edge_in | input | 42 | Shared input vector seen by all decoders |
| term_o | output | 8 | Product terms, two per decoder (lower at even index) |
| sum_o | output | 2 | OR-plane outputs |

## Verification
The assertions take two things for granted. First, cfg_addr stays inside the populated range whenever cfg_we is high. Second, cfg_we is low while reset is held, so the first post-reset comparison sees only cleared registers. The bench drives writes only to legal addresses and holds the strobe low throughout reset. It changes inputs and the strobe on falling edges, which keeps the same-edge write and hold properties well defined. For every configuration it sweeps all input patterns of a six-input, two-decoder instance and compares each term and sum with a model built from the requirements.

// File: rtl/wpd_pkg.sv
`timescale 1ns/1ps
package wpd_pkg;

    typedef enum logic [1:0] {
        SEL_SKIP = 2'b00,
        SEL_POS  = 2'b01,
        SEL_NEG  = 2'b10,
        SEL_RSVD = 2'b11
    } lit_sel_e;

    // One literal of a product term; ignored selectors contribute a 1.
    function automatic logic lit_eval(input lit_sel_e sel, input logic bit_in);
        logic r;
        unique case (sel)
            SEL_POS:  r = bit_in;
            SEL_NEG:  r = ~bit_in;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wpd_cfg_store.sv
`timescale 1ns/1ps
module wpd_cfg_store #(
    parameter int N_IN   = 42,
    parameter int N_DEC  = 4,
    parameter int N_OR   = 2,
    parameter int N_TERM = 2 * N_DEC,
    parameter int CFG_W  = 2 * N_IN + 1,
    parameter int ADDR_W = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [CFG_W-1:0]                  cfg_data,
    output logic [N_DEC-1:0][2*N_IN-1:0]      sel_o,
    output logic [N_DEC-1:0]                  split_o,
    output logic [N_OR-1:0][N_TERM-1:0]       mask_o
);

    localparam int SPLIT_BIT = 2 * N_IN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o   <= '0;
            split_o <= '0;
            mask_o  <= '0;
        end else if (cfg_we) begin
            for (int d = 0; d < N_DEC; d++) begin
                if (cfg_addr == ADDR_W'(d)) begin
                    sel_o[d]   <= cfg_data[2*N_IN-1:0];
                    split_o[d] <= cfg_data[SPLIT_BIT];
                end
            end
            for (int k = 0; k < N_OR; k++) begin
                if (cfg_addr == ADDR_W'(N_DEC + k)) begin
                    mask_o[k] <= cfg_data[N_TERM-1:0];
                end
            end
        end
    end

    for (genvar d = 0; d < N_DEC; d++) begin : g_dec_chk
        // R7: a write to entry d is visible after the edge that took it
        assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cfg_we) && ($past(cfg_addr) == ADDR_W'(d)))
            |-> (sel_o[d] == $past(cfg_data[2*N_IN-1:0]) &&
                 split_o[d] == $past(cfg_data[SPLIT_BIT])));
        // R7: entries not addressed keep their contents
        assert_entry_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !($past(cfg_we) && ($past(cfg_addr) == ADDR_W'(d))))
            |-> ($stable(sel_o[d]) && $stable(split_o[d])));
        // R8: leaving reset finds cleared selectors and flags
        assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (sel_o[d] == '0 && !split_o[d]));
    end

    for (genvar k = 0; k < N_OR; k++) begin : g_or_chk
        assert_mask_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (mask_o[k] == '0));
    end

endmodule

// File: rtl/wpd_pterm.sv
`timescale 1ns/1ps
module wpd_pterm #(
    parameter int N_IN = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   edge_in,
    input  logic [2*N_IN-1:0] sel_i,
    input  logic              split_i,
    output logic              lo_o,
    output logic              hi_o
);

    localparam int HALF = N_IN / 2;

    logic [N_IN-1:0] lit;
    logic            and_all;
    logic            and_lo;
    logic            and_hi;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[i] = wpd_pkg::lit_eval(wpd_pkg::lit_sel_e'(sel_i[2*i +: 2]), edge_in[i]);
    end

    always_comb begin
        and_all = &lit;
        and_lo  = &lit[HALF-1:0];
        and_hi  = &lit[N_IN-1:HALF];
        lo_o    = split_i ? and_lo : and_all;
        hi_o    = split_i & and_hi;
    end

    // R5: an unsplit decoder never raises its upper term
    assert_upper_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !split_i |-> !hi_o);
    // R6: in split mode the lower term ignores the upper half entirely
    assert_lower_indep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(split_i) && split_i && $stable(edge_in[HALF-1:0]) &&
         $stable(sel_i[2*HALF-1:0])) |-> $stable(lo_o));
    // R6: in split mode the upper term ignores the lower half entirely
    assert_upper_indep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(split_i) && split_i && $stable(edge_in[N_IN-1:HALF]) &&
         $stable(sel_i[2*N_IN-1:2*HALF])) |-> $stable(hi_o));

endmodule

// File: rtl/wpd_or_plane.sv
`timescale 1ns/1ps
module wpd_or_plane #(
    parameter int N_TERM = 8,
    parameter int N_OR   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_TERM-1:0]           term_i,
    input  logic [N_OR-1:0][N_TERM-1:0] mask_i,
    output logic [N_OR-1:0]             sum_o
);

    for (genvar k = 0; k < N_OR; k++) begin : g_sum
        assign sum_o[k] = |(term_i & mask_i[k]);

        // R10: no enabled terms means a low sum
        assert_empty_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i[k] == '0) |-> !sum_o[k]);
        // R9: a single enabled, high term is enough to raise the sum
        assert_hit_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(term_i & mask_i[k]) != 0) |-> sum_o[k]);
        // R9: with every term low the sum is low whatever the mask
        assert_no_hit_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (term_i == '0) |-> !sum_o[k]);
    end

endmodule

// File: rtl/wide_pterm_decoder.sv
`timescale 1ns/1ps
module wide_pterm_decoder #(
    parameter int N_IN  = 42,
    parameter int N_DEC = 4,
    parameter int N_OR  = 2,
    localparam int N_TERM = 2 * N_DEC,
    localparam int CFG_W  = 2 * N_IN + 1,
    localparam int N_ENT  = N_DEC + N_OR,
    localparam int ADDR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [N_IN-1:0]   edge_in,
    output logic [N_TERM-1:0] term_o,
    output logic [N_OR-1:0]   sum_o
);

    logic [N_DEC-1:0][2*N_IN-1:0] sel_q;
    logic [N_DEC-1:0]             split_q;
    logic [N_OR-1:0][N_TERM-1:0]  mask_q;

    wpd_cfg_store #(
        .N_IN   (N_IN),
        .N_DEC  (N_DEC),
        .N_OR   (N_OR),
        .N_TERM (N_TERM),
        .CFG_W  (CFG_W),
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .sel_o    (sel_q),
        .split_o  (split_q),
        .mask_o   (mask_q)
    );

    for (genvar d = 0; d < N_DEC; d++) begin : g_dec
        wpd_pterm #(
            .N_IN (N_IN)
        ) u_pterm (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_in (edge_in),
            .sel_i   (sel_q[d]),
            .split_i (split_q[d]),
            .lo_o    (term_o[2*d]),
            .hi_o    (term_o[2*d+1])
        );
    end

    wpd_or_plane #(
        .N_TERM (N_TERM),
        .N_OR   (N_OR)
    ) u_or (
        .clk    (clk),
        .rst_n  (rst_n),
        .term_i (term_o),
        .mask_i (mask_q),
        .sum_o  (sum_o)
    );

    // R4: all-ignore decoder (unsplit) yields a high whole term
    for (genvar d = 0; d < N_DEC; d++) begin : g_top_chk
        assert_all_skip_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!split_q[d] && ($countones(sel_q[d]) == 0)) |-> term_o[2*d]);
    end

endmodule

// File: tb/wide_pterm_decoder_tb.sv
`timescale 1ns/1ps
module wide_pterm_decoder_tb;

    localparam int NI = 6;
    localparam int ND = 2;
    localparam int NO = 2;
    localparam int NT = 2 * ND;
    localparam int CW = 2 * NI + 1;
    localparam int AW = 2;
    localparam int H  = NI / 2;
    localparam logic [1:0] OF = 2'b00, TR = 2'b01, CP = 2'b10, RS = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_data = '0;
    logic [NI-1:0] edge_in = '0;
    logic [NT-1:0] term_o;
    logic [NO-1:0] sum_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [ND-1:0][2*NI-1:0] m_sel;
    logic [ND-1:0]           m_split;
    logic [NO-1:0][NT-1:0]   m_mask;

    always #4 clk = ~clk;

    wide_pterm_decoder #(.N_IN(NI), .N_DEC(ND), .N_OR(NO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .edge_in(edge_in), .term_o(term_o), .sum_o(sum_o)
    );

    function automatic logic exp_term(int t, logic [NI-1:0] x);
        int  d = t / 2;
        bit  up = (t % 2) == 1;
        int  lo = 0;
        int  hi = NI - 1;
        logic r = 1'b1;
        if (!m_split[d] && up) return 1'b0;
        if (m_split[d]) begin
            if (up) lo = H; else hi = H - 1;
        end
        for (int i = lo; i <= hi; i++) begin
            if (m_sel[d][2*i +: 2] == TR) r &= x[i];
            else if (m_sel[d][2*i +: 2] == CP) r &= ~x[i];
        end
        return r;
    endfunction

    function automatic logic [NT-1:0] exp_terms(logic [NI-1:0] x);
        logic [NT-1:0] v;
        for (int t = 0; t < NT; t++) v[t] = exp_term(t, x);
        return v;
    endfunction

    function automatic logic [NO-1:0] exp_sums(logic [NI-1:0] x);
        logic [NO-1:0] s;
        logic [NT-1:0] v = exp_terms(x);
        for (int k = 0; k < NO; k++) s[k] = |(v & m_mask[k]);
        return s;
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    task automatic sweep(string req);
        for (int x = 0; x < (1 << NI); x++) begin
            @(negedge clk);
            edge_in = NI'(x);
            #1;
            check(req, $sformatf("terms x=%0h", x), 32'(term_o), 32'(exp_terms(NI'(x))));
            check(req, $sformatf("sums x=%0h", x), 32'(sum_o), 32'(exp_sums(NI'(x))));
        end
    endtask

    task automatic write_raw(int addr, logic [CW-1:0] data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = AW'(addr);
        cfg_data = data;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic set_dec(int d, logic [2*NI-1:0] sel, logic sp);
        write_raw(d, {sp, sel});
        m_sel[d]   = sel;
        m_split[d] = sp;
    endtask

    task automatic set_mask(int k, logic [NT-1:0] mask);
        write_raw(ND + k, CW'(mask));
        m_mask[k] = mask;
    endtask

    task automatic model_reset();
        m_sel   = '0;
        m_split = '0;
        m_mask  = '0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R8: outputs in reset
        check("R8", "terms in reset", 32'(term_o), 32'b0101);
        check("R8", "sums in reset", 32'(sum_o), 32'b00);
        rst_n = 1'b1;
        // R8 R4 R5 R10: cleared configuration over all inputs
        sweep("R8 R4 R5 R10");

        // R1 R2 R3 R5: decoder 0 whole, with true, complement, 00 and 11 selectors
        set_dec(0, {CP, TR, RS, OF, CP, TR}, 1'b0);
        // R6 R4: decoder 1 split, lower uses inputs 0,1 true, upper all ignored
        set_dec(1, {OF, OF, OF, OF, TR, TR}, 1'b1);
        set_mask(0, 4'b1001);
        set_mask(1, 4'b0000);
        sweep("R1 R2 R3 R4 R5 R6 R9 R10");

        // R6 R4 R9: lower half all ignored, upper half mixed, full mask
        set_dec(0, {CP, OF, OF, OF, OF, OF}, 1'b0);
        set_dec(1, {CP, TR, CP, OF, OF, OF}, 1'b1);
        set_mask(0, 4'b0110);
        set_mask(1, 4'b1111);
        sweep("R2 R4 R6 R9");

        // R7: new selector becomes visible only after the clock edge
        @(negedge clk);
        edge_in  = '0;
        cfg_we   = 1'b1;
        cfg_addr = AW'(0);
        cfg_data = {1'b0, OF, OF, OF, OF, OF, TR};
        #1;
        check("R7", "term0 before edge", 32'(term_o[0]), 32'd1);
        @(negedge clk);
        cfg_we = 1'b0;
        m_sel[0] = {OF, OF, OF, OF, OF, TR};
        #1;
        check("R7", "term0 after edge", 32'(term_o[0]), 32'd0);
        // R7: the other entries are unchanged by that write
        sweep("R7 R1 R6");

        // R5: decoder 1 back to whole, upper term forced low
        set_dec(1, {CP, TR, CP, OF, OF, OF}, 1'b0);
        set_mask(0, 4'b1010);
        sweep("R5 R9");

        // R8: asynchronous reset in mid-run clears everything
        @(negedge clk);
        edge_in = NI'(6'b101010);
        rst_n = 1'b0;
        #1;
        model_reset();
        check("R8", "terms after mid reset", 32'(term_o), 32'b0101);
        check("R8", "sums after mid reset", 32'(sum_o), 32'b00);
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R8 R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule